// File: doc/BRIEF.md
# Isochronous Receive Context Control Bank

This block keeps the control word of eight isochronous receive DMA contexts. Software changes each word through a pair of addresses. Ones written to the set address turn bits on. Ones written to the clear address turn bits off. Zeros written to either address have no effect. Each word holds five mode bits (buffer fill, header keep, cycle-match start, multi-channel, dual buffer), a software `run` bit and a hardware `active` flag. The stored mode bits drive the receive datapath as per-context output vectors.

Each context has its own start controller with four states:
- `ST_IDLE` waits for `run`. It moves to `ST_START` when cycle-match start is off or the cycle already matches, and to `ST_ARMED` otherwise.
- `ST_ARMED` waits for the 15-bit cycle value to equal the context's programmed cycle. It moves to `ST_START` on a match, or back to `ST_IDLE` if `run` drops.
- `ST_START` lasts one cycle. It drives the start pulse and raises `active`, then moves to `ST_RUNNING` (or to `ST_IDLE` if `run` has dropped).
- `ST_RUNNING` holds `active` until `run` drops, then returns to `ST_IDLE`.

On the transition into `ST_START`, hardware clears the cycle-match start bit. Mode bits are frozen while `run` or `active` is set. A per-context channel filter tells the packet receiver which running contexts take the channel of the current packet. Status outputs flag illegal mode combinations and more than one multi-channel context.

Top module: `irctl_bank`

## Requirements
- R1: After reset every control word reads zero, and no start pulse, active flag, channel accept, error or conflict output is asserted.
- R2: For context n, a write to byte address 0x400+32n ORs the write data into the word, and a write to 0x404+32n clears the bits that are one in the data. The bit positions are: 31 buffer fill, 30 header keep, 29 cycle-match start, 28 multi-channel, 27 dual buffer, 15 run, 10 active (read-only). A read at either address returns the word. All other bits, including 26:16, read zero. A read at any other address returns zero.
- R3: When run is set and cycle-match start is clear, `run_start` pulses for exactly one cycle, one cycle after the register shows run. `ctx_active` rises in the same cycle as the pulse.
- R4: When run is set and cycle-match start is set, no start pulse occurs until `cycle_time[26:12]` equals bits 26:12 of the context's match word. The pulse appears one cycle after the match is presented. Timer bits outside 26:12 are ignored.
- R5: The cycle-match start bit is cleared by hardware in the cycle the context becomes active.
- R6: While run or active is set, writes to bits 31:27 are ignored. The run bit itself can still be written.
- R7: When run is cleared, active drops one cycle later. Clearing run in `ST_ARMED` cancels the pending start, so no pulse follows a later match.
- R8: `cfg_err[n]` is high while context n holds multi-channel without buffer fill, or dual buffer together with multi-channel or buffer fill.
- R9: `multi_conflict` is high while more than one context has multi-channel set.
- R10: A running context without multi-channel accepts a packet whose `rx_chan` equals bits 5:0 of its match word.
- R11: A running context with multi-channel accepts a packet when `chan_mask[rx_chan]` is one, and ignores its match channel. A context whose run bit is clear accepts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 12 | Byte address for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cycle_time | input | 32 | Bus cycle timer; bits 26:12 are compared |
| ctx_match | input | 256 | Match words, context n at bits 32n+31:32n |
| rx_chan | input | 6 | Channel of the packet being received |
| chan_mask | input | 64 | Channel enable mask for multi-channel mode |
| mode_fill | output | 8 | Buffer fill bit per context |
| mode_hdr | output | 8 | Header keep bit per context |
| mode_cme | output | 8 | Cycle-match start bit per context |
| mode_multi | output | 8 | Multi-channel bit per context |
| mode_dual | output | 8 | Dual buffer bit per context |
| ctx_run | output | 8 | Run bit per context |
| ctx_active | output | 8 | Active flag per context |
| run_start | output | 8 | One-cycle start pulse per context |
| chan_accept | output | 8 | Per-context accept for `rx_chan` |
| cfg_err | output | 8 | Illegal mode combination per context |
| multi_conflict | output | 1 | More than one multi-channel context |

## Verification
Results are due at different times:
- Stored bits show on the mode outputs in the first cycle after the write edge.
- A start pulse comes one cycle after run is visible, or one cycle after a matching cycle value is presented. `active` follows the pulse.
- `active` falls one cycle after run is cleared.
- Channel accept, read data and the two status outputs are combinational.

The driver queues each timed expectation tagged with its due cycle. The monitor compares it at the falling edge of that cycle. The pulse is checked both in its cycle and in the next one, which catches an early, late or stretched pulse. Combinational results are checked a short delay after their inputs change, between clock edges.

// File: rtl/irctl_pkg.sv
package irctl_pkg;
    localparam int BIT_FILL  = 31;
    localparam int BIT_HDR   = 30;
    localparam int BIT_CME   = 29;
    localparam int BIT_MULTI = 28;
    localparam int BIT_DUAL  = 27;
    localparam int BIT_RUN   = 15;
    localparam int BIT_ACT   = 10;
    localparam int CM_HI     = 26;
    localparam int CM_LO     = 12;

    typedef struct packed {
        logic fill;
        logic hdr;
        logic cme;
        logic multi;
        logic dual;
        logic run;
    } ctx_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_START,
        ST_RUNNING
    } ctx_state_t;
endpackage

// File: rtl/irctl_ctx_reg.sv
module irctl_ctx_reg
    import irctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_we,
    input  logic        clr_we,
    input  logic [31:0] wdata,
    input  logic        hw_clr_cme,
    input  logic        active,
    output ctx_mode_t   mode
);
    ctx_mode_t nxt;
    logic      locked;
    logic      unused_wdata;

    assign unused_wdata = ^{wdata[26:16], wdata[14:0]};
    assign locked = mode.run | active;

    always_comb begin
        nxt = mode;
        if (set_we) begin
            if (!locked) begin
                nxt.fill  = mode.fill  | wdata[BIT_FILL];
                nxt.hdr   = mode.hdr   | wdata[BIT_HDR];
                nxt.cme   = mode.cme   | wdata[BIT_CME];
                nxt.multi = mode.multi | wdata[BIT_MULTI];
                nxt.dual  = mode.dual  | wdata[BIT_DUAL];
            end
            nxt.run = mode.run | wdata[BIT_RUN];
        end
        if (clr_we) begin
            if (!locked) begin
                nxt.fill  = nxt.fill  & ~wdata[BIT_FILL];
                nxt.hdr   = nxt.hdr   & ~wdata[BIT_HDR];
                nxt.cme   = nxt.cme   & ~wdata[BIT_CME];
                nxt.multi = nxt.multi & ~wdata[BIT_MULTI];
                nxt.dual  = nxt.dual  & ~wdata[BIT_DUAL];
            end
            nxt.run = nxt.run & ~wdata[BIT_RUN];
        end
        if (hw_clr_cme) begin
            nxt.cme = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0;
        end else begin
            mode <= nxt;
        end
    end

    // R6: mode bits other than the hardware-cleared one hold while locked
    a_r6_mode_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.run || active) |=> ($stable(mode.fill) && $stable(mode.hdr) &&
                                  $stable(mode.multi) && $stable(mode.dual)));
endmodule

// File: rtl/irctl_ctx_fsm.sv
module irctl_ctx_fsm
    import irctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cme,
    input  logic cyc_hit,
    output logic start,
    output logic active,
    output logic hw_clr_cme
);
    ctx_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (run) begin
                    state_nxt = (cme && !cyc_hit) ? ST_ARMED : ST_START;
                end
            end
            ST_ARMED: begin
                if (!run) begin
                    state_nxt = ST_IDLE;
                end else if (cyc_hit) begin
                    state_nxt = ST_START;
                end
            end
            ST_START: begin
                state_nxt = run ? ST_RUNNING : ST_IDLE;
            end
            ST_RUNNING: begin
                if (!run) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        start      = (state == ST_START);
        active     = (state == ST_START) || (state == ST_RUNNING);
        hw_clr_cme = (state_nxt == ST_START) && (state != ST_START);
    end

    // R3: the start pulse never lasts two cycles
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    // R5: cycle-match start is already clear while the pulse is out
    a_r5_cme_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !cme);
    // R4: no start while armed without a cycle match
    a_r4_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !cyc_hit) |=> !start);
    // R7: a cleared run bit drops active on the next cycle
    a_r7_stop_drops_active: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !active);
endmodule

// File: rtl/irctl_chan_filter.sv
module irctl_chan_filter #(
    parameter int CHAN_W = 6,
    localparam int MASK_W = 1 << CHAN_W
) (
    input  logic              run,
    input  logic              multi,
    input  logic [CHAN_W-1:0] match_chan,
    input  logic [CHAN_W-1:0] rx_chan,
    input  logic [MASK_W-1:0] chan_mask,
    output logic              accept
);
    always_comb begin
        if (!run) begin
            accept = 1'b0;
        end else if (multi) begin
            accept = chan_mask[rx_chan];
        end else begin
            accept = (rx_chan == match_chan);
        end
    end
endmodule

// File: rtl/irctl_bank.sv
module irctl_bank
    import irctl_pkg::*;
#(
    parameter int NCTX   = 8,
    parameter int ADDR_W = 12,
    parameter int BASE   = 'h400,
    parameter int STRIDE = 32,
    parameter int CHAN_W = 6,
    localparam int IDX_W  = $clog2(NCTX),
    localparam int OFF_W  = $clog2(STRIDE),
    localparam int SPAN   = NCTX * STRIDE,
    localparam int MASK_W = 1 << CHAN_W,
    localparam int CM_W   = CM_HI - CM_LO + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_we,
    output logic [31:0]         bus_rdata,
    input  logic [31:0]         cycle_time,
    input  logic [NCTX*32-1:0]  ctx_match,
    input  logic [CHAN_W-1:0]   rx_chan,
    input  logic [MASK_W-1:0]   chan_mask,
    output logic [NCTX-1:0]     mode_fill,
    output logic [NCTX-1:0]     mode_hdr,
    output logic [NCTX-1:0]     mode_cme,
    output logic [NCTX-1:0]     mode_multi,
    output logic [NCTX-1:0]     mode_dual,
    output logic [NCTX-1:0]     ctx_run,
    output logic [NCTX-1:0]     ctx_active,
    output logic [NCTX-1:0]     run_start,
    output logic [NCTX-1:0]     chan_accept,
    output logic [NCTX-1:0]     cfg_err,
    output logic                multi_conflict
);
    logic [ADDR_W-1:0] rel;
    logic              in_win, is_set, is_clr;
    logic [IDX_W-1:0]  idx;
    logic [31:0]       ctx_word [NCTX];
    logic              unused_time;

    assign unused_time = ^{cycle_time[31:CM_HI+1], cycle_time[CM_LO-1:0], rel};

    always_comb begin
        rel    = bus_addr - ADDR_W'(BASE);
        in_win = (int'(bus_addr) >= BASE) && (int'(bus_addr) < BASE + SPAN);
        idx    = rel[OFF_W +: IDX_W];
        is_set = in_win && (rel[OFF_W-1:0] == OFF_W'(0));
        is_clr = in_win && (rel[OFF_W-1:0] == OFF_W'(4));
    end

    for (genvar g = 0; g < NCTX; g++) begin : g_ctx
        ctx_mode_t mode;
        logic      set_we, clr_we, hw_clr, act, start, hit, acc;
        logic      unused_match;

        assign unused_match = ^{ctx_match[g*32+31 -: 31-CM_HI],
                                ctx_match[g*32+CM_LO-1 : g*32+CHAN_W]};
        assign set_we = bus_we && is_set && (idx == IDX_W'(g));
        assign clr_we = bus_we && is_clr && (idx == IDX_W'(g));
        assign hit    = (cycle_time[CM_HI:CM_LO] == ctx_match[g*32+CM_HI -: CM_W]);

        irctl_ctx_reg u_reg (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_we     (set_we),
            .clr_we     (clr_we),
            .wdata      (bus_wdata),
            .hw_clr_cme (hw_clr),
            .active     (act),
            .mode       (mode)
        );

        irctl_ctx_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (mode.run),
            .cme        (mode.cme),
            .cyc_hit    (hit),
            .start      (start),
            .active     (act),
            .hw_clr_cme (hw_clr)
        );

        irctl_chan_filter #(.CHAN_W(CHAN_W)) u_filt (
            .run        (mode.run),
            .multi      (mode.multi),
            .match_chan (ctx_match[g*32 +: CHAN_W]),
            .rx_chan    (rx_chan),
            .chan_mask  (chan_mask),
            .accept     (acc)
        );

        always_comb begin
            ctx_word[g]            = '0;
            ctx_word[g][BIT_FILL]  = mode.fill;
            ctx_word[g][BIT_HDR]   = mode.hdr;
            ctx_word[g][BIT_CME]   = mode.cme;
            ctx_word[g][BIT_MULTI] = mode.multi;
            ctx_word[g][BIT_DUAL]  = mode.dual;
            ctx_word[g][BIT_RUN]   = mode.run;
            ctx_word[g][BIT_ACT]   = act;
        end

        assign mode_fill[g]   = mode.fill;
        assign mode_hdr[g]    = mode.hdr;
        assign mode_cme[g]    = mode.cme;
        assign mode_multi[g]  = mode.multi;
        assign mode_dual[g]   = mode.dual;
        assign ctx_run[g]     = mode.run;
        assign ctx_active[g]  = act;
        assign run_start[g]   = start;
        assign chan_accept[g] = acc;
        assign cfg_err[g]     = (mode.multi && !mode.fill) ||
                                (mode.dual && (mode.multi || mode.fill));

        // R11: a context only accepts packets while its run bit is set
        a_r11_accept_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
            chan_accept[g] |-> ctx_run[g]);
        // R3: the start pulse and the active flag rise together
        a_r3_start_with_active: assert property (@(posedge clk) disable iff (!rst_n)
            run_start[g] |-> ctx_active[g]);
    end

    assign bus_rdata      = (is_set || is_clr) ? ctx_word[idx] : '0;
    assign multi_conflict = ($countones(mode_multi) > 1);

    // R2: the reserved field never reads back as one
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[26:16] == 11'd0);
endmodule

// File: tb/irctl_bank_bench.sv
module irctl_bank_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_rdata;
    logic [31:0]  cycle_time = '0;
    logic [255:0] ctx_match = '0;
    logic [5:0]   rx_chan = '0;
    logic [63:0]  chan_mask = '0;
    logic [7:0]   mode_fill, mode_hdr, mode_cme, mode_multi, mode_dual;
    logic [7:0]   ctx_run, ctx_active, run_start, chan_accept, cfg_err;
    logic         multi_conflict;

    irctl_bank u_irctl_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .cycle_time(cycle_time),
        .ctx_match(ctx_match), .rx_chan(rx_chan), .chan_mask(chan_mask),
        .mode_fill(mode_fill), .mode_hdr(mode_hdr), .mode_cme(mode_cme),
        .mode_multi(mode_multi), .mode_dual(mode_dual), .ctx_run(ctx_run),
        .ctx_active(ctx_active), .run_start(run_start), .chan_accept(chan_accept),
        .cfg_err(cfg_err), .multi_conflict(multi_conflict)
    );

    always #10 clk = ~clk;

    localparam int S_START = 0, S_ACT = 1, S_RUN = 2, S_CME = 3, S_MULTI = 4,
                   S_FILL = 5, S_ERR = 6, S_CONF = 7, S_HDR = 8;

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc++;

    function automatic logic [31:0] observe(int sel);
        case (sel)
            S_START: return {24'd0, run_start};
            S_ACT:   return {24'd0, ctx_active};
            S_RUN:   return {24'd0, ctx_run};
            S_CME:   return {24'd0, mode_cme};
            S_MULTI: return {24'd0, mode_multi};
            S_FILL:  return {24'd0, mode_fill};
            S_ERR:   return {24'd0, cfg_err};
            S_CONF:  return {31'd0, multi_conflict};
            default: return {24'd0, mode_hdr};
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_in(int off, int sel, logic [31:0] v, string req);
        sbq.push_back('{cyc + off, sel, v, req});
    endtask

    initial begin
        forever begin
            @(negedge clk);
            for (int i = sbq.size() - 1; i >= 0; i--) begin
                if (sbq[i].due <= cyc) begin
                    check(sbq[i].req, observe(sbq[i].sel), sbq[i].val);
                    sbq.delete(i);
                end
            end
        end
    end

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_check(logic [11:0] a, logic [31:0] exp, string req);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic acc_check(logic [5:0] ch, logic [7:0] exp, string req);
        rx_chan = ch;
        #1;
        check(req, {24'd0, chan_accept}, {24'd0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 start", {24'd0, run_start}, 32'd0);
        check("R1 active", {24'd0, ctx_active}, 32'd0);
        check("R1 modes", {mode_fill, mode_hdr, mode_cme, mode_multi}, 32'd0);
        check("R1 errs", {23'd0, multi_conflict, cfg_err}, 32'd0);
        check("R1 accept", {24'd0, chan_accept}, 32'd0);
        rd_check(12'h400, 32'd0, "R1 word");
        tick(1);

        // R2: reserved and unused bits, unmapped addresses
        wr(12'h4E0, 32'h07FF_7BFF);
        rd_check(12'h4E0, 32'd0, "R2 reserved bits");
        wr(12'h408, 32'hF800_8000);
        rd_check(12'h400, 32'd0, "R2 non set/clear offset");
        rd_check(12'h300, 32'd0, "R2 unmapped read");

        // R2/R3: context 2 modes then immediate start
        wr(12'h440, 32'hC000_0000);
        expect_in(1, S_FILL, 32'h04, "R2 fill set");
        expect_in(1, S_HDR, 32'h04, "R2 hdr set");
        wr(12'h440, 32'h0000_8000);
        expect_in(1, S_START, 32'h04, "R3 pulse");
        expect_in(1, S_ACT, 32'h04, "R3 active with pulse");
        expect_in(2, S_START, 32'h00, "R3 pulse one cycle");
        expect_in(2, S_ACT, 32'h04, "R3 active holds");
        tick(3);
        rd_check(12'h440, 32'hC000_8400, "R2 word via set addr");
        rd_check(12'h444, 32'hC000_8400, "R2 word via clear addr");

        // R6: mode writes ignored while running
        wr(12'h444, 32'h8000_0000);
        expect_in(1, S_FILL, 32'h04, "R6 fill clear ignored");
        wr(12'h440, 32'h1000_0000);
        expect_in(1, S_MULTI, 32'h00, "R6 multi set ignored");
        tick(2);

        // R7: clearing run
        wr(12'h444, 32'h0000_8000);
        expect_in(1, S_RUN, 32'h00, "R7 run cleared");
        expect_in(1, S_ACT, 32'h00, "R7 active drops");
        tick(1);
        wr(12'h444, 32'hC000_0000);
        expect_in(1, S_FILL, 32'h00, "R6 fill clear after stop");
        tick(2);

        // R4/R5: cycle-match start on context 5
        ctx_match[5*32 +: 32] = 32'h1234 << 12;
        wr(12'h4A0, 32'h2000_8000);
        expect_in(1, S_START, 32'h00, "R4 no start before match");
        expect_in(1, S_CME, 32'h20, "R4 cme held while armed");
        expect_in(2, S_START, 32'h00, "R4 no start while armed");
        tick(3);
        cycle_time = (32'h1235 << 12) | 32'h0000_0ABC;
        expect_in(1, S_START, 32'h00, "R4 near miss");
        expect_in(2, S_ACT, 32'h00, "R4 not active on miss");
        tick(3);
        cycle_time = 32'hF800_0000 | (32'h1234 << 12) | 32'h0000_0FFF;
        expect_in(1, S_START, 32'h20, "R4 pulse on match");
        expect_in(1, S_ACT, 32'h20, "R4 active on match");
        expect_in(1, S_CME, 32'h00, "R5 cme self clear");
        expect_in(2, S_START, 32'h00, "R4 pulse one cycle");
        tick(3);
        wr(12'h4A4, 32'h0000_8000);
        cycle_time = 32'd0;
        tick(2);

        // R7: cancel a pending cycle-match start on context 6
        ctx_match[6*32 +: 32] = 32'h0100 << 12;
        wr(12'h4C0, 32'h2000_8000);
        tick(2);
        wr(12'h4C4, 32'h0000_8000);
        tick(1);
        cycle_time = 32'h0100 << 12;
        expect_in(1, S_START, 32'h00, "R7 cancelled start");
        expect_in(2, S_ACT, 32'h00, "R7 stays inactive");
        expect_in(2, S_CME, 32'h40, "R7 cme kept after cancel");
        tick(3);
        cycle_time = 32'd0;
        wr(12'h4C4, 32'h2000_0000);

        // R8: illegal combinations
        wr(12'h420, 32'h1000_0000);
        expect_in(1, S_ERR, 32'h02, "R8 multi without fill");
        tick(1);
        wr(12'h420, 32'h8000_0000);
        expect_in(1, S_ERR, 32'h00, "R8 multi with fill legal");
        tick(1);
        wr(12'h460, 32'h8800_0000);
        expect_in(1, S_ERR, 32'h08, "R8 dual with fill");
        tick(1);
        wr(12'h464, 32'h8000_0000);
        expect_in(1, S_ERR, 32'h00, "R8 dual alone legal");
        tick(1);

        // R9: multi-channel conflict
        wr(12'h480, 32'h9000_0000);
        expect_in(1, S_CONF, 32'h1, "R9 two multi contexts");
        tick(1);
        wr(12'h484, 32'h1000_0000);
        expect_in(1, S_CONF, 32'h0, "R9 one multi context");
        tick(2);

        // R10/R11: channel acceptance
        chan_mask = (64'd1 << 7) | (64'd1 << 40);
        ctx_match[0*32 +: 32] = 32'd9;
        ctx_match[3*32 +: 32] = 32'd9;
        ctx_match[1*32 +: 32] = 32'd7;
        wr(12'h420, 32'h0000_8000);
        wr(12'h400, 32'h0000_8000);
        tick(2);
        acc_check(6'd7, 8'h02, "R11 mask bit 7");
        acc_check(6'd40, 8'h02, "R11 mask bit 40");
        acc_check(6'd9, 8'h01, "R10 single channel match, stopped ctx ignored");
        acc_check(6'd8, 8'h00, "R10 no match");
        wr(12'h404, 32'h0000_8000);
        acc_check(6'd9, 8'h00, "R11 stopped context accepts nothing");
        tick(4);
        finish_run();
    end
endmodule